// File: doc/BRIEF.md
# Carrier-Gated Serial Receive Front End

This block sits between a synchronous serial line and the receiver that frames and deserializes it. Every rising edge of the receive clock is one bit time. On each edge the block decides from a carrier-detect input whether the bit on the data line is passed on. Frame boundaries come from the receiver as two plain inputs: a frame-active level and a last-bit marker. Accepted bits leave as a one-cycle valid strobe with data. The block also reports the end of reception and keeps a carrier-lost flag for the current frame.

Two configuration bits set how carrier-detect is used. The timing bit chooses between a synchronized path, where the carrier passes through a flop synchronizer before it counts, and a direct path, where the level at the clock edge counts at once. The hold bit chooses between envelope operation and pulse operation. In envelope operation the carrier has to frame the data, and a drop before the last bit aborts the frame with an error. In pulse operation the carrier only opens the frame.

The output stream has a valid strobe but no ready input. A serial line cannot be paused, so the consumer must take every strobed bit in the cycle it appears. All outputs are registered and change one edge after the inputs they reflect.

Top module: `cdg_rx_gate`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `rx_end` and `rx_lost` are 0.
- R2: With `cfg_direct`=0, the carrier level counts on the third rising edge after it was first sampled. The edge that samples it counts as the first. No bit of a frame is accepted before that edge.
- R3: With `cfg_direct`=1, the carrier level present at an edge gates that same edge's bit. In envelope operation every accepted bit had `carrier_in`=1 at its edge.
- R4: A bit accepted at edge k shows up as `out_valid`=1 with `out_data` equal to that edge's `rx_data`, from edge k until edge k+1.
- R5: With `cfg_pulse`=0, an effective carrier of 0 after the first accepted bit and before the frame's last bit stops reception. `rx_lost` is set, and no further bit of that frame is accepted.
- R6: The carrier-loss abort raises `rx_end` at the same edge that sets `rx_lost`. In synchronized mode this is two edges later than in direct mode.
- R7: With `cfg_pulse`=1, `rx_lost` never rises, and carrier negation after the first accepted bit has no effect on acceptance.
- R8: When the last bit of a frame is accepted (`last_bit`=1 with `frame_act`=1), `rx_end` pulses for one cycle and `rx_lost` is not set.
- R9: `rx_lost` holds its value between frames. It clears at the first edge of the next frame, meaning the first edge with `frame_act`=1 after a last bit or after an idle gap.
- R10: Carrier negation at or after the edge following the last bit, or between frames, never sets `rx_lost`.
- R11: No bit is accepted on an edge with `frame_act`=0. Dropping `frame_act` without a last bit abandons the frame silently, without `rx_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | DATA_W | Serial data for the current bit time |
| frame_act | input | 1 | High during the bit times of a frame |
| last_bit | input | 1 | Marks the final bit time of a frame |
| carrier_in | input | 1 | Carrier-detect, active high |
| cfg_direct | input | 1 | 1: direct carrier timing, 0: synchronized |
| cfg_pulse | input | 1 | 1: pulse operation, 0: envelope operation |
| out_valid | output | 1 | Strobe for an accepted bit |
| out_data | output | DATA_W | Accepted bit |
| rx_end | output | 1 | One-cycle pulse when reception of a frame ends |
| rx_lost | output | 1 | Carrier-lost flag of the most recent frame |

## Verification
The checker watches four things on every edge. In envelope operation each accepted bit must have had an effective carrier, direct or synchronized. A rise of `rx_lost` must come with `rx_end` and must fall inside a frame. A strobe must never appear without a frame. Pulse operation must never raise the flag. Several behaviours span many cycles and only the bench scenarios can show them: the exact edge at which a carrier start or drop takes effect in each timing mode, the lifetime of the lost flag across idle gaps, quiet handling of late negation, and abandoned frames. The bench sweeps carrier on and off edges against frame position and length in all four mode combinations.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

  typedef enum logic [1:0] {
    RX_WAIT = 2'd0,
    RX_RECV = 2'd1,
    RX_HALT = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic accept;
    logic finish;
    logic lost;
    logic start;
  } rx_event_t;

endpackage

// File: rtl/cdg_carrier_sync.sv
module cdg_carrier_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic synced
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= raw_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign synced = chain[LAST];
endmodule

// File: rtl/cdg_carrier_select.sv
module cdg_carrier_select (
  input  logic direct_mode,
  input  logic raw_level,
  input  logic synced_level,
  output logic carrier_eff
);
  always_comb begin
    if (direct_mode) carrier_eff = raw_level;
    else             carrier_eff = synced_level;
  end
endmodule

// File: rtl/cdg_frame_ctrl.sv
module cdg_frame_ctrl
  import cdg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_act,
  input  logic      last_bit,
  input  logic      carrier_eff,
  input  logic      pulse_mode,
  output rx_event_t evt
);
  rx_state_e state_q, state_d;
  logic      in_frame_q, in_frame_d;

  always_comb begin
    evt        = '0;
    state_d    = state_q;
    in_frame_d = in_frame_q;
    if (frame_act) begin
      evt.start = !in_frame_q;
      unique case (state_q)
        RX_WAIT: begin
          if (carrier_eff) begin
            evt.accept = 1'b1;
            state_d    = RX_RECV;
          end
        end
        RX_RECV: begin
          if (!pulse_mode && !carrier_eff) begin
            evt.lost   = 1'b1;
            evt.finish = 1'b1;
            state_d    = RX_HALT;
          end else begin
            evt.accept = 1'b1;
          end
        end
        default: ;
      endcase
      if (evt.accept && last_bit) evt.finish = 1'b1;
      if (last_bit) begin
        state_d    = RX_WAIT;
        in_frame_d = 1'b0;
      end else begin
        in_frame_d = 1'b1;
      end
    end else begin
      state_d    = RX_WAIT;
      in_frame_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_WAIT;
      in_frame_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      in_frame_q <= in_frame_d;
    end
  end
endmodule

// File: rtl/cdg_out_stage.sv
module cdg_out_stage
  import cdg_pkg::*;
#(
  parameter int DATA_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_event_t         evt,
  input  logic [DATA_W-1:0] bit_in,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q,
  output logic              end_q,
  output logic              lost_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      end_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      valid_q <= evt.accept;
      if (evt.accept) data_q <= bit_in;
      end_q <= evt.finish;
      if (evt.lost)       lost_q <= 1'b1;
      else if (evt.start) lost_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cdg_rx_gate.sv
module cdg_rx_gate
  import cdg_pkg::*;
#(
  parameter int DATA_W      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              frame_act,
  input  logic              last_bit,
  input  logic              carrier_in,
  input  logic              cfg_direct,
  input  logic              cfg_pulse,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              rx_end,
  output logic              rx_lost
);
  logic      car_sync;
  logic      car_eff;
  rx_event_t evt;

  cdg_carrier_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (rx_clk),
    .rst_n  (rst_n),
    .raw_in (carrier_in),
    .synced (car_sync)
  );

  cdg_carrier_select u_sel (
    .direct_mode  (cfg_direct),
    .raw_level    (carrier_in),
    .synced_level (car_sync),
    .carrier_eff  (car_eff)
  );

  cdg_frame_ctrl u_ctrl (
    .clk         (rx_clk),
    .rst_n       (rst_n),
    .frame_act   (frame_act),
    .last_bit    (last_bit),
    .carrier_eff (car_eff),
    .pulse_mode  (cfg_pulse),
    .evt         (evt)
  );

  cdg_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (rx_clk),
    .rst_n   (rst_n),
    .evt     (evt),
    .bit_in  (rx_data),
    .valid_q (out_valid),
    .data_q  (out_data),
    .end_q   (rx_end),
    .lost_q  (rx_lost)
  );
endmodule

// File: rtl/cdg_rx_gate_checker.sv
module cdg_rx_gate_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_act,
  input logic carrier_in,
  input logic cfg_direct,
  input logic cfg_pulse,
  input logic car_sync,
  input logic out_valid,
  input logic rx_end,
  input logic rx_lost
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !rx_end && !rx_lost) || rst_n);

  a_r2_sync_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(!cfg_direct && !cfg_pulse)) |-> $past(car_sync));

  a_r3_direct_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_direct && !cfg_pulse)) |-> $past(carrier_in));

  a_r6_lost_ends: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lost) |-> rx_end);

  a_r7_pulse_no_lost: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lost) |-> $past(!cfg_pulse));

  a_r10_lost_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lost) |-> $past(frame_act));

  a_r11_valid_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frame_act));
endmodule

bind cdg_rx_gate cdg_rx_gate_checker u_chk (
  .clk        (rx_clk),
  .rst_n      (rst_n),
  .frame_act  (frame_act),
  .carrier_in (carrier_in),
  .cfg_direct (cfg_direct),
  .cfg_pulse  (cfg_pulse),
  .car_sync   (car_sync),
  .out_valid  (out_valid),
  .rx_end     (rx_end),
  .rx_lost    (rx_lost)
);

// File: tb/cdg_rx_gate_test.sv
module cdg_rx_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [0:0] rx_data = '0;
  logic frame_act = 1'b0, last_bit = 1'b0, carrier_in = 1'b0;
  logic cfg_direct = 1'b0, cfg_pulse = 1'b0;
  logic out_valid, rx_end, rx_lost;
  logic [0:0] out_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit late_drop = 0;

  // reference state
  logic m_started = 0, m_halt = 0, m_inframe = 0, m_lost = 0;
  logic cd1 = 0, cd2 = 0;
  logic m_data = 0;

  always #2 clk = ~clk;

  cdg_rx_gate uut (
    .rx_clk(clk), .rst_n(rst_n), .rx_data(rx_data), .frame_act(frame_act),
    .last_bit(last_bit), .carrier_in(carrier_in), .cfg_direct(cfg_direct),
    .cfg_pulse(cfg_pulse), .out_valid(out_valid), .out_data(out_data),
    .rx_end(rx_end), .rx_lost(rx_lost)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic step(input logic fa, input logic lb, input logic car, input logic d);
    logic ce, ev, ee, lev, fs;
    @(negedge clk);
    frame_act = fa; last_bit = lb; carrier_in = car; rx_data = d;
    ce = cfg_direct ? car : cd2;
    ev = 0; ee = 0; lev = 0; fs = 0;
    if (fa) begin
      fs = !m_inframe;
      if (!m_halt) begin
        if (!m_started) begin
          if (ce) begin m_started = 1; ev = 1; end
        end else if (!cfg_pulse && !ce) begin
          m_halt = 1; ee = 1; lev = 1;
        end else ev = 1;
      end
      if (ev && lb) ee = 1;
      if (lb) begin m_started = 0; m_halt = 0; m_inframe = 0; end
      else m_inframe = 1;
    end else begin
      m_started = 0; m_halt = 0; m_inframe = 0;
    end
    if (lev) m_lost = 1;
    else if (fs) m_lost = 0;
    if (ev) m_data = d;
    cd2 = cd1; cd1 = car;
    @(posedge clk); #1;
    chk(!fa ? "R11" : (cfg_direct ? "R3" : "R2"), out_valid, ev);
    if (ev) chk("R4", out_data[0], m_data);
    chk(lev ? "R6" : "R8", rx_end, ee);
    chk(cfg_pulse ? "R7" : (late_drop ? "R10" : (!fa ? "R9" : "R5")), rx_lost, m_lost);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", out_valid, 1'b0);
    chk("R1", rx_end, 1'b0);
    chk("R1", rx_lost, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // sweep: timing mode, hold mode, frame length, carrier on/off edges
    for (int dm = 0; dm < 2; dm++) begin
      for (int pm = 0; pm < 2; pm++) begin
        for (int len = 1; len <= 5; len++) begin
          for (int on_t = 0; on_t <= 6; on_t++) begin
            for (int off_t = on_t + 1; off_t <= len + 7; off_t++) begin
              @(negedge clk);
              cfg_direct = dm[0];
              cfg_pulse  = pm[0];
              late_drop  = (off_t >= 3 + len);
              for (int t = 0; t < len + 7; t++) begin
                logic fa, lb, car;
                fa  = (t >= 3) && (t < 3 + len);
                lb  = (t == 2 + len);
                car = (t >= on_t) && (t < off_t);
                step(fa, lb, car, logic'(((t * 5 + off_t * 3 + len) % 3) == 1));
              end
              late_drop = 0;
            end
          end
        end
      end
    end

    // R11: frame abandoned without a last bit, carrier held, direct envelope
    @(negedge clk);
    cfg_direct = 1'b1; cfg_pulse = 1'b0;
    step(0, 0, 1, 0);
    step(1, 0, 1, 1);
    step(1, 0, 1, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 1);
    step(1, 0, 1, 1);
    step(1, 1, 1, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // R9: lost flag survives an idle gap and clears on the next frame
    step(1, 0, 1, 1);
    step(1, 0, 0, 1);
    step(1, 1, 0, 1);
    repeat (4) step(0, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    repeat (3) step(0, 0, 0, 0);

    finish_run();
  end
endmodule